// File: doc/BRIEF.md
# Drift Chamber Track Segment Finder

This block looks at hit bits from a group of four drift-chamber layers and decides, for every cell of the second layer, whether a short straight track segment crosses it. The second layer is the anchor ("pivot") layer. Around each pivot cell there is a fixed set of eight cell combinations, one cell per layer. A pivot cell reports a segment in two strengths:
- a strict flag, raised when all four cells of some combination carry hits;
- a tolerant flag, raised when any three of the four do.

Every hit line is registered first. It then passes through a per-line programmable delay, which lines up the wires in time. Finally it is stretched over a programmable number of clocks to cover the spread in drift time. Only after that are the combinations evaluated. The logic is fully pipelined and has no dead time, so every clock is examined.

Cells at the two ends of the board need hits that belong to adjacent boards. The left neighbour supplies its last A, C and D cells. The right neighbour supplies its first D cell. This board in turn exports its own boundary hits, one clock after the input register. A simple write port sets each line's delay and the common stretch length.

Top module: `dc_segment_finder`

## Requirements
- R1: After reset, `seg_strict`, `seg_tol`, `nb_left_out` and `nb_right_out` are all zero. Every line delay is 0 and the stretch length is 1 clock. With these defaults, a single-clock hit gives an output pulse exactly one clock long.
- R2: Pivot i (layer B cell i) has eight combinations: A(i-1) or A(i); then C(i-1) with D(i-1) or D(i), or C(i) with D(i) or D(i+1). `seg_strict[i]` is set when all four cells of at least one combination are hit. With delay 0, hits sampled at clock edge k show at the output after edge k+2.
- R3: `seg_tol[i]` is set when any three of the four cells of at least one combination of pivot i are hit. A set `seg_strict[i]` always has `seg_tol[i]` set as well.
- R4: Cells outside the eight combinations never complete a strict segment. For example, A(i), B(i), C(i-1), D(i+1) give strict 0 and tolerant 1 at pivot i.
- R5: For pivot 0, A(-1), C(-1) and D(-1) come from `nb_left_in` bits [0], [1] and [2]. For pivot N-1, D(N) comes from `nb_right_in[0]`.
- R6: A line with delay code d (0..15) reaches the pattern logic d clocks later than with delay 0. Lines with unequal delays that are hit in the same clock do not coincide when the stretch length is 1.
- R7: Stretch code s (0..15) holds a hit for s+1 clocks. A hit arriving while a line is already stretched restarts the full length.
- R8: `nb_right_out` = {D, C, A} of cell N-1 at bits [2], [1], [0]. `nb_left_out` = D of cell 0. Both are the inputs as registered one clock earlier.
- R9: A write with `cfg_we` sets the delay of a line at the following addresses:
  - A(i) at address i;
  - B(i) at N+i;
  - C(i) at 2N+i;
  - D(i) at 3N+i;
  - left-neighbour A, C, D at 4N, 4N+1 and 4N+2;
  - right-neighbour D at 4N+3.

  Address 4N+4 writes the stretch code. Any higher address is ignored.
- R10: Hits on consecutive or alternate clocks each produce their own output. There is no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_a | input | N_PIVOT | Layer A cell hits |
| hit_b | input | N_PIVOT | Layer B (pivot) cell hits |
| hit_c | input | N_PIVOT | Layer C cell hits |
| hit_d | input | N_PIVOT | Layer D cell hits |
| nb_left_in | input | 3 | Left neighbour's last cells {D,C,A} |
| nb_right_in | input | 1 | Right neighbour's first D cell |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address (see R9) |
| cfg_wdata | input | CFG_W | Delay or stretch code |
| nb_left_out | output | 1 | Registered D of cell 0 for the left board |
| nb_right_out | output | 3 | Registered {D,C,A} of cell N-1 for the right board |
| seg_strict | output | N_PIVOT | Four-of-four segment flag per pivot |
| seg_tol | output | N_PIVOT | Three-of-four segment flag per pivot |

## Verification
The assertions take for granted that every hit, neighbour and configuration input holds a defined 0 or 1 from the first clock after reset. They also assume that the stretched layer lines are the only path to a segment flag, so a quiet pipeline must give quiet outputs. The bench therefore drives every input to a known value at the falling edge and clears all hits after each pulse. It applies configuration writes only while no hits are in flight, so that each latency and overlap window it checks begins from an empty pipeline.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  // Bit positions inside the three-wide neighbour buses (R5, R8).
  localparam int EDGE_A = 0;
  localparam int EDGE_C = 1;
  localparam int EDGE_D = 2;
  localparam int EDGE_W = 3;

  // Number of cell combinations anchored on one pivot cell.
  localparam int N_COMBO = 8;

  // Lane group base addresses in the configuration space.
  function automatic int lane_base_a(input int n); return 0;     endfunction
  function automatic int lane_base_b(input int n); return n;     endfunction
  function automatic int lane_base_c(input int n); return 2 * n; endfunction
  function automatic int lane_base_d(input int n); return 3 * n; endfunction

endpackage

// File: rtl/tsf_cfg_regs.sv
module tsf_cfg_regs #(
  parameter int NL = 132,
  parameter int AW = 8,
  parameter int CW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [CW-1:0]          cfg_wdata,
  output logic [NL-1:0][CW-1:0]  dly_o,
  output logic [CW-1:0]          str_o
);

  localparam logic [AW-1:0] STR_ADDR = AW'(NL);

  logic [NL-1:0][CW-1:0] dly_q, dly_d;
  logic [CW-1:0]         str_q, str_d;
  logic                  dly_en, str_en;

  always_comb begin
    str_en = cfg_we && (cfg_addr == STR_ADDR);
    dly_en = cfg_we && (cfg_addr < STR_ADDR);
    dly_d  = dly_q;
    str_d  = str_q;
    if (str_en) str_d = cfg_wdata;
    if (dly_en) dly_d[cfg_addr] = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      str_q <= '0;
    end else begin
      if (dly_en) dly_q <= dly_d;
      if (str_en) str_q <= str_d;
    end
  end

  assign dly_o = dly_q;
  assign str_o = str_q;

endmodule

// File: rtl/tsf_lane.sv
module tsf_lane #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [CW-1:0] dly_i,
  input  logic [CW-1:0] str_i,
  output logic          hit_o
);

  localparam int DEPTH = (1 << CW) - 1;
  localparam int CNT_W = CW + 1;

  logic [DEPTH-1:0] sh_q, sh_d;
  logic [DEPTH:0]   taps;
  logic             tapped;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Tap 0 is the undelayed hit, tap k the hit k clocks old.
  always_comb begin
    sh_d   = {sh_q[DEPTH-2:0], hit_i};
    taps   = {sh_q, hit_i};
    tapped = taps[dly_i];
  end

  // Retriggerable stretcher: every arriving hit reloads the full length.
  always_comb begin
    if (tapped)
      cnt_d = CNT_W'(str_i) + CNT_W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = (cnt_q != '0);

endmodule

// File: rtl/tsf_match.sv
module tsf_match
  import tsf_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N:0]   a_x,
  input  logic [N-1:0] b_i,
  input  logic [N:0]   c_x,
  input  logic [N+1:0] d_x,
  output logic [N-1:0] strict_o,
  output logic [N-1:0] tol_o
);

  // Extended index e corresponds to cell e-1, so index 0 is the left edge
  // and d_x[N+1] is the right edge.
  for (genvar p = 0; p < N; p++) begin : g_pivot
    logic [N_COMBO-1:0] full4;
    logic [N_COMBO-1:0] any3;
    for (genvar k = 0; k < N_COMBO; k++) begin : g_combo
      localparam int AI = p + ((k >> 2) & 1);
      localparam int CI = p + ((k >> 1) & 1);
      localparam int DI = CI + (k & 1);
      logic ca, cb, cc, cd;
      assign ca = a_x[AI];
      assign cb = b_i[p];
      assign cc = c_x[CI];
      assign cd = d_x[DI];
      assign full4[k] = ca & cb & cc & cd;
      assign any3[k]  = (ca & cb & cc) | (ca & cb & cd) |
                        (ca & cc & cd) | (cb & cc & cd);
    end
    assign strict_o[p] = |full4;
    assign tol_o[p]    = |any3;
  end

endmodule

// File: rtl/dc_segment_finder.sv
module dc_segment_finder
  import tsf_pkg::*;
#(
  parameter  int N_PIVOT = 32,
  parameter  int CFG_W   = 4,
  localparam int NL      = 4 * N_PIVOT + 4,
  localparam int ADDR_W  = $clog2(NL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PIVOT-1:0] hit_a,
  input  logic [N_PIVOT-1:0] hit_b,
  input  logic [N_PIVOT-1:0] hit_c,
  input  logic [N_PIVOT-1:0] hit_d,
  input  logic [EDGE_W-1:0]  nb_left_in,
  input  logic               nb_right_in,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               nb_left_out,
  output logic [EDGE_W-1:0]  nb_right_out,
  output logic [N_PIVOT-1:0] seg_strict,
  output logic [N_PIVOT-1:0] seg_tol
);

  localparam int N      = N_PIVOT;
  localparam int BA     = lane_base_a(N);
  localparam int BB     = lane_base_b(N);
  localparam int BC     = lane_base_c(N);
  localparam int BD     = lane_base_d(N);
  localparam int L_EDGE = 4 * N;
  localparam int R_EDGE = 4 * N + EDGE_W;

  // Input register stage
  logic [NL-1:0] in_d, in_q;

  always_comb in_d = {nb_right_in, nb_left_in, hit_d, hit_c, hit_b, hit_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= in_d;
  end

  assign nb_right_out = {in_q[BD + N - 1], in_q[BC + N - 1], in_q[BA + N - 1]};
  assign nb_left_out  = in_q[BD];

  // Configuration
  logic [NL-1:0][CFG_W-1:0] dly_cfg;
  logic [CFG_W-1:0]         str_code;

  tsf_cfg_regs #(.NL(NL), .AW(ADDR_W), .CW(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .dly_o     (dly_cfg),
    .str_o     (str_code)
  );

  // Delay and stretch per line
  logic [NL-1:0] str_v;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    tsf_lane #(.CW(CFG_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (in_q[g]),
      .dly_i (dly_cfg[g]),
      .str_i (str_code),
      .hit_o (str_v[g])
    );
  end

  // Extended layer vectors, edge cells at both ends
  logic [N:0]   a_x;
  logic [N:0]   c_x;
  logic [N+1:0] d_x;
  logic [N-1:0] b_s;

  always_comb begin
    a_x = {str_v[BA +: N], str_v[L_EDGE + EDGE_A]};
    c_x = {str_v[BC +: N], str_v[L_EDGE + EDGE_C]};
    d_x = {str_v[R_EDGE], str_v[BD +: N], str_v[L_EDGE + EDGE_D]};
    b_s = str_v[BB +: N];
  end

  logic [N-1:0] strict_d, tol_d;

  tsf_match #(.N(N)) u_match (
    .a_x      (a_x),
    .b_i      (b_s),
    .c_x      (c_x),
    .d_x      (d_x),
    .strict_o (strict_d),
    .tol_o    (tol_d)
  );

  // Output register stage
  logic [N-1:0] strict_q, tol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strict_q <= '0;
      tol_q    <= '0;
    end else begin
      strict_q <= strict_d;
      tol_q    <= tol_d;
    end
  end

  assign seg_strict = strict_q;
  assign seg_tol    = tol_q;

endmodule

// File: rtl/dc_segment_finder_chk.sv
module dc_segment_finder_chk #(
  parameter int N  = 32,
  parameter int CW = 4,
  parameter int AW = 8,
  parameter int NL = 132
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  hit_a,
  input logic [N-1:0]  hit_c,
  input logic [N-1:0]  hit_d,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_addr,
  input logic [CW-1:0] cfg_wdata,
  input logic [N-1:0]  seg_strict,
  input logic [N-1:0]  seg_tol,
  input logic          nb_left_out,
  input logic [2:0]    nb_right_out,
  input logic [NL-1:0] str_v,
  input logic [CW-1:0] str_code
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  strict_in_tol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_strict & ~seg_tol) == '0));

  // R2
  strict_needs_pivot_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ((seg_strict & ~$past(str_v[2*N-1:N])) == '0));

  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(str_v) == '0) |-> (seg_tol == '0));

  // R7
  stretch_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(NL)) |=> (str_code == $past(cfg_wdata)));

  // R8
  edge_right_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    nb_right_out == $past({hit_d[N-1], hit_c[N-1], hit_a[N-1]}));

  // R8
  edge_left_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    nb_left_out == $past(hit_d[0]));

endmodule

bind dc_segment_finder dc_segment_finder_chk #(
  .N(N_PIVOT), .CW(CFG_W), .AW(ADDR_W), .NL(NL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hit_a        (hit_a),
  .hit_c        (hit_c),
  .hit_d        (hit_d),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .seg_strict   (seg_strict),
  .seg_tol      (seg_tol),
  .nb_left_out  (nb_left_out),
  .nb_right_out (nb_right_out),
  .str_v        (str_v),
  .str_code     (str_code)
);

// File: tb/sim_dc_segment_finder.sv
module sim_dc_segment_finder;

  localparam int N      = 32;
  localparam int CW     = 4;
  localparam int NL     = 4 * N + 4;
  localparam int AW     = $clog2(NL + 1);
  localparam int TCLK   = 10;
  localparam int NV     = 15;
  localparam int STR_AD = 4 * N + 4;

  // Vector: pivot[14:10], local pattern[9:2], exp strict[1], exp tol[0].
  // Pattern bits: A(i-1) A(i) B(i) C(i-1) C(i) D(i-1) D(i) D(i+1).
  localparam logic [14:0] VEC [NV] = '{
    {5'd5,  8'b01101010, 1'b1, 1'b1},  // R2 A(i) C(i) D(i)
    {5'd5,  8'b10110100, 1'b1, 1'b1},  // R2 all left-leaning
    {5'd5,  8'b01110010, 1'b1, 1'b1},  // R2 C(i-1) D(i)
    {5'd5,  8'b01101001, 1'b1, 1'b1},  // R2 C(i) D(i+1)
    {5'd5,  8'b01110001, 1'b0, 1'b1},  // R4 C(i-1) with D(i+1)
    {5'd5,  8'b01101000, 1'b0, 1'b1},  // R3 D missing
    {5'd5,  8'b01001010, 1'b0, 1'b1},  // R3 B missing
    {5'd5,  8'b00101010, 1'b0, 1'b1},  // R3 A missing
    {5'd5,  8'b01100000, 1'b0, 1'b0},  // R3 two cells only
    {5'd5,  8'b00100100, 1'b0, 1'b0},  // R3 two cells only
    {5'd5,  8'b10110001, 1'b0, 1'b1},  // R4 three of a valid combo
    {5'd0,  8'b10110100, 1'b1, 1'b1},  // R5 left edge cells
    {5'd31, 8'b01101001, 1'b1, 1'b1},  // R5 right edge cell
    {5'd0,  8'b00010100, 1'b0, 1'b0},  // R5 edge cells alone
    {5'd9,  8'b00000000, 1'b0, 1'b0}   // R2 empty
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  hit_a, hit_b, hit_c, hit_d;
  logic [2:0]    nb_left_in;
  logic          nb_right_in;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_wdata;
  logic          nb_left_out;
  logic [2:0]    nb_right_out;
  logic [N-1:0]  seg_strict, seg_tol;

  int n_checks;
  int n_fails;

  dc_segment_finder #(.N_PIVOT(N), .CFG_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c), .hit_d(hit_d),
    .nb_left_in(nb_left_in), .nb_right_in(nb_right_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .nb_left_out(nb_left_out), .nb_right_out(nb_right_out),
    .seg_strict(seg_strict), .seg_tol(seg_tol)
  );

  initial clk = 1'b0;
  always #(TCLK / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    hit_a = '0; hit_b = '0; hit_c = '0; hit_d = '0;
    nb_left_in = '0; nb_right_in = 1'b0;
  endtask

  task automatic set_pat(input int p, input logic [7:0] pat);
    if (pat[7]) begin if (p == 0) nb_left_in[0] = 1'b1; else hit_a[p-1] = 1'b1; end
    if (pat[6]) hit_a[p] = 1'b1;
    if (pat[5]) hit_b[p] = 1'b1;
    if (pat[4]) begin if (p == 0) nb_left_in[1] = 1'b1; else hit_c[p-1] = 1'b1; end
    if (pat[3]) hit_c[p] = 1'b1;
    if (pat[2]) begin if (p == 0) nb_left_in[2] = 1'b1; else hit_d[p-1] = 1'b1; end
    if (pat[1]) hit_d[p] = 1'b1;
    if (pat[0]) begin if (p == N-1) nb_right_in = 1'b1; else hit_d[p+1] = 1'b1; end
  endtask

  // Reference: eight combinations per pivot from the requirement text.
  task automatic model(output logic [N-1:0] es, output logic [N-1:0] et);
    logic [N+1:0] ea, ec, ed;
    ea = '0; ec = '0; ed = '0;
    ea[0] = nb_left_in[0]; ec[0] = nb_left_in[1]; ed[0] = nb_left_in[2];
    ed[N+1] = nb_right_in;
    for (int j = 0; j < N; j++) begin
      ea[j+1] = hit_a[j]; ec[j+1] = hit_c[j]; ed[j+1] = hit_d[j];
    end
    es = '0; et = '0;
    for (int p = 0; p < N; p++) begin
      for (int ai = 0; ai < 2; ai++) begin
        for (int cs = 0; cs < 2; cs++) begin
          for (int ds = 0; ds < 2; ds++) begin
            int cnt;
            cnt = int'(ea[p+ai]) + int'(hit_b[p]) + int'(ec[p+cs]) + int'(ed[p+cs+ds]);
            if (cnt == 4) es[p] = 1'b1;
            if (cnt >= 3) et[p] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic write_cfg(input int addr, input int val);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = CW'(val);
    tick(1);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  localparam logic [7:0] FULL = 8'b01101010;

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [N-1:0] es, et, one5;
    n_checks = 0; n_fails = 0;
    one5 = N'(1) << 5;
    clear_all();
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 strict after reset", seg_strict, '0);
    chk("R1 tol after reset", seg_tol, '0);
    chk("R1 exports after reset", N'({nb_left_out, nb_right_out}), '0);

    // R1 defaults: delay 0, one-clock stretch
    set_pat(5, FULL); model(es, et);
    tick(1); clear_all(); tick(2);
    chk("R1 default latency", seg_strict, es);
    tick(1);
    chk("R1 default one-clock pulse", seg_strict, '0);
    tick(3);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int p;
      p = int'(VEC[v][14:10]);
      set_pat(p, VEC[v][9:2]); model(es, et);
      tick(1); clear_all(); tick(2);
      chk($sformatf("R2/R3 vec %0d strict pivot", v), N'(seg_strict[p]), N'(VEC[v][1]));
      chk($sformatf("R3/R4 vec %0d tol pivot", v), N'(seg_tol[p]), N'(VEC[v][0]));
      chk($sformatf("R2 vec %0d strict all", v), seg_strict, es);
      chk($sformatf("R3 vec %0d tol all", v), seg_tol, et);
      tick(3);
    end

    // R6 equal delay of 3 on all four cells of pivot 5
    write_cfg(5, 3); write_cfg(N + 5, 3); write_cfg(2*N + 5, 3); write_cfg(3*N + 5, 3);
    tick(2);
    set_pat(5, FULL); model(es, et);
    tick(1); clear_all(); tick(2);
    chk("R6 delayed not early", seg_strict, '0);
    tick(3);
    chk("R6 delayed strict", seg_strict, es);
    chk("R6 delayed tol", seg_tol, et);
    tick(1);
    chk("R6 delayed pulse ends", seg_strict, '0);
    write_cfg(5, 0); write_cfg(N + 5, 0); write_cfg(2*N + 5, 0); write_cfg(3*N + 5, 0);
    tick(2);

    // R6 misaligned pivot line (R9 address of B(5))
    write_cfg(N + 5, 2);
    tick(2);
    set_pat(5, FULL);
    tick(1); clear_all(); tick(2);
    chk("R6 misaligned strict N3", seg_strict, '0);
    chk("R6 three on time tol", N'(seg_tol[5]), N'(1));
    tick(2);
    chk("R6 misaligned strict N5", seg_strict, '0);
    write_cfg(N + 5, 0);
    tick(3);

    // R9 out-of-range address ignored
    write_cfg(200, 7);
    tick(2);
    set_pat(5, FULL); model(es, et);
    tick(1); clear_all(); tick(2);
    chk("R9 bad address ignored", seg_strict, es);
    tick(1);
    chk("R9 stretch unchanged", seg_strict, '0);
    tick(3);

    // R10 alternate-clock hits
    set_pat(5, FULL); model(es, et);
    tick(1); clear_all(); tick(1); set_pat(5, FULL);
    tick(1); clear_all();
    chk("R10 first hit", seg_strict, es);
    tick(1);
    chk("R10 gap", seg_strict, '0);
    tick(1);
    chk("R10 second hit", seg_strict, es);
    tick(3);

    // R8 neighbour exports
    hit_a[N-1] = 1'b1; hit_d[N-1] = 1'b1; hit_d[0] = 1'b1;
    tick(1); clear_all();
    chk("R8 right export", N'(nb_right_out), N'(3'b101));
    chk("R8 left export", N'(nb_left_out), N'(1));
    tick(1);
    chk("R8 exports clear", N'({nb_left_out, nb_right_out}), '0);
    tick(4);

    // R7 stretch length 4
    write_cfg(STR_AD, 3);
    tick(2);
    set_pat(5, FULL); model(es, et);
    tick(1); clear_all(); tick(2);
    chk("R7 stretch start", seg_strict, es);
    tick(3);
    chk("R7 stretch last clock", seg_strict, es);
    tick(1);
    chk("R7 stretch over", seg_strict, '0);
    tick(6);

    // R7 staggered D overlaps thanks to stretch
    set_pat(5, 8'b01101000);
    tick(1); clear_all(); tick(1); set_pat(5, 8'b00000010);
    tick(1); clear_all(); tick(2);
    chk("R7 overlap first", seg_strict, one5);
    tick(1);
    chk("R7 overlap second", seg_strict, one5);
    tick(1);
    chk("R7 overlap ends", seg_strict, '0);
    tick(6);

    // R7 retrigger restarts the count
    set_pat(5, FULL); model(es, et);
    tick(1); clear_all(); tick(2); set_pat(5, FULL);
    tick(1); clear_all(); tick(5);
    chk("R7 retrigger extends", seg_strict, es);
    tick(1);
    chk("R7 retrigger ends", seg_strict, '0);
    tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule